// File: doc/BRIEF.md
# DDR2 Column Command Burst Sequencer

This block sits in an SDRAM controller behind the row-activation logic. Once a row is open, it takes column read and write requests through a ready/valid handshake. Each request carries a start column, a burst length of 4 or 8, and a beat order that is either sequential or interleaved. The block encodes each accepted request onto the four command pins. Between commands it keeps the pins at NOP. It also holds back any request that arrives before the minimum column-to-column spacing has elapsed.

For each burst, the block produces the column address of every beat, two beats per clock. All beats stay inside the aligned block of burst-length columns that holds the start column. For reads, it raises a data-valid strobe that lines up with the programmed read latency of 3 to 5 clocks. An 8-beat read may be cut short by a new 8-beat read that is flagged as an interruption. A 4-beat burst always runs to completion.

Top module: `ddr2_col_seq`

## Requirements
- R1: In the cycle after a request is accepted, the pins show a column command: cmd_cs_n=0, cmd_ras_n=1, cmd_cas_n=0, and cmd_we_n=1 for a read or 0 for a write. In that same cycle cmd_col equals the requested column.
- R2: In every cycle that does not carry a column command, and after reset, the pins show NOP ({cs_n,ras_n,cas_n,we_n}=4'b0111).
- R3: A request whose req_valid is high while req_ready is low is not taken. It stays pending and is issued in the cycle after req_ready is seen high.
- R4: After a 4-beat command, the next command appears no sooner than 2 clocks later, so a 4-beat burst is never cut short.
- R5: After an 8-beat command, the next command appears no sooner than 4 clocks later, unless R12 applies.
- R6: In a 4-beat sequential burst, beat b uses column bits [1:0] equal to (start[1:0]+b) mod 4. All higher bits stay those of the start column.
- R7: In an 8-beat sequential burst, beat b uses column bits [2:0] equal to (start[2:0]+b) mod 8. All higher bits stay those of the start column.
- R8: In interleaved order, the low bits of beat b are the low start bits XOR b. This uses 2 bits for 4-beat bursts and 3 bits for 8-beat bursts.
- R9: bst_valid is high for BL/2 consecutive cycles, starting in the command cycle. Beat 2k appears on bst_col_even and beat 2k+1 on bst_col_odd in the k-th of those cycles. bst_write shows the direction of the burst.
- R10: For a read with rd_lat = RL (3, 4 or 5), rd_valid is high exactly in the cycles RL through RL+BL/2-1 after the command cycle. Writes produce no rd_valid.
- R11: Read commands issued exactly at the minimum spacing give an unbroken run of rd_valid cycles.
- R12: A read request with req_intr=1 and burst length 8 may be issued 2 or 3 clocks after an 8-beat read. It ends the old burst and starts the new one. req_intr has no effect on writes, on 4-beat requests, or after a 4-beat command.
- R13: After reset, req_ready is high and bst_valid and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_lat | input | 3 | Read latency in clocks, 3 to 5, changed only while idle |
| req_valid | input | 1 | Column request present |
| req_ready | output | 1 | Request may be taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bl8 | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| req_intlv | input | 1 | 1 = interleaved beat order, 0 = sequential |
| req_intr | input | 1 | Request may interrupt a running 8-beat read |
| req_col | input | 12 | Start column |
| cmd_cs_n | output | 1 | Chip select pin, active low |
| cmd_ras_n | output | 1 | Row strobe pin, active low |
| cmd_cas_n | output | 1 | Column strobe pin, active low |
| cmd_we_n | output | 1 | Write enable pin, active low |
| cmd_col | output | 12 | Column presented with the latest command |
| bst_valid | output | 1 | Beat-pair addresses valid this cycle |
| bst_write | output | 1 | Current burst is a write |
| bst_col_even | output | 12 | Column of the even beat of the pair |
| bst_col_odd | output | 12 | Column of the odd beat of the pair |
| rd_valid | output | 1 | Read data beats expected this cycle |

## Verification
Some properties are checked on every cycle:
- the pin encoding on an accepted request, and NOP otherwise;
- a 4-beat burst never being followed by a command in its first clock;
- the 8-beat spacing counter still being busy two clocks after an 8-beat command;
- every beat staying in the start column's aligned block;
- the two beats of a pair differing;
- the read latency staying within 3 to 5.

Only the directed scenarios can show the exact beat orders, the measured command spacings, the placement and length of the rd_valid window at each latency, gap-free streaming, and which requests an interruption flag is allowed to shorten.

// File: rtl/ddr2cs_pkg.sv
package ddr2cs_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } order_e;

  function automatic pins_t col_cmd(input logic is_write);
    pins_t p;
    p.cs_n  = 1'b0;
    p.ras_n = 1'b1;
    p.cas_n = 1'b0;
    p.we_n  = ~is_write;
    return p;
  endfunction

endpackage

// File: rtl/ddr2cs_spacing.sv
module ddr2cs_spacing #(
  parameter int TCCD_SHORT = 2,
  parameter int TCCD_LONG  = 4,
  parameter int INTR_MIN   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic req_bl8,
  input  logic req_write,
  input  logic req_intr,
  output logic ready
);
  localparam int GAP_W = $clog2(TCCD_LONG);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic             cur_bl8_q, cur_bl8_d;
  logic             cur_rd_q, cur_rd_d;
  logic             intr_ok;

  // Interruption only read-by-read, 8-beat over 8-beat, after INTR_MIN clocks.
  always_comb begin
    intr_ok = req_intr & req_bl8 & ~req_write & cur_bl8_q & cur_rd_q &
              (gap_q != '0) & (gap_q <= GAP_W'(TCCD_LONG - INTR_MIN));
    ready   = (gap_q == '0) | intr_ok;
  end

  always_comb begin
    gap_d     = gap_q;
    cur_bl8_d = cur_bl8_q;
    cur_rd_d  = cur_rd_q;
    if (accept) begin
      gap_d     = req_bl8 ? GAP_W'(TCCD_LONG - 1) : GAP_W'(TCCD_SHORT - 1);
      cur_bl8_d = req_bl8;
      cur_rd_d  = ~req_write;
    end else if (gap_q != '0) begin
      gap_d = gap_q - GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      cur_bl8_q <= 1'b0;
      cur_rd_q  <= 1'b0;
    end else begin
      gap_q <= gap_d;
      if (accept) begin
        cur_bl8_q <= cur_bl8_d;
        cur_rd_q  <= cur_rd_d;
      end
    end
  end

  // R4: one clock after a 4-beat command no request may be taken
  p_short_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_bl8 |=> !ready);

  // R5: two clocks after an 8-beat command the spacing is still running
  p_long_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_bl8 |=> ##1 (gap_q != '0));

endmodule

// File: rtl/ddr2cs_burst.sv
module ddr2cs_burst
  import ddr2cs_pkg::*;
#(
  parameter int COL_W  = 12,
  parameter int BPC    = 2,
  parameter int MAX_BL = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [COL_W-1:0]          ld_col,
  input  logic                      ld_bl8,
  input  logic                      ld_intlv,
  input  logic                      ld_write,
  output logic                      bst_valid,
  output logic                      bst_last,
  output logic                      bst_bl8,
  output logic                      bst_write,
  output logic [BPC-1:0][COL_W-1:0] bst_col
);
  localparam int OFF_W     = $clog2(MAX_BL);
  localparam int PAIRS_BL8 = MAX_BL / BPC;
  localparam int PAIRS_BL4 = (MAX_BL / 2) / BPC;
  localparam int CNT_W     = $clog2(PAIRS_BL8);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, last_idx;
  logic [COL_W-1:0] base_q;
  logic             bl8_q, wr_q;
  order_e           ord_q;
  logic             upd;

  always_comb begin
    last_idx = bl8_q ? CNT_W'(PAIRS_BL8 - 1) : CNT_W'(PAIRS_BL4 - 1);
    bst_last = active_q & (cnt_q == last_idx);
    upd      = load | active_q;
    active_d = active_q;
    cnt_d    = cnt_q;
    if (load) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (bst_last) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (active_q) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      bl8_q    <= 1'b0;
      wr_q     <= 1'b0;
      ord_q    <= ORD_SEQ;
    end else begin
      if (upd) begin
        active_q <= active_d;
        cnt_q    <= cnt_d;
      end
      if (load) begin
        base_q <= ld_col;
        bl8_q  <= ld_bl8;
        wr_q   <= ld_write;
        ord_q  <= order_e'(ld_intlv);
      end
    end
  end

  assign bst_valid = active_q;
  assign bst_bl8   = bl8_q;
  assign bst_write = wr_q;

  for (genvar i = 0; i < BPC; i++) begin : g_beat
    logic [OFF_W-1:0] idx, seq_off, ilv_off, off;
    always_comb begin
      idx     = OFF_W'(cnt_q) * OFF_W'(BPC) + OFF_W'(i);
      seq_off = base_q[OFF_W-1:0] + idx;
      ilv_off = base_q[OFF_W-1:0] ^ idx;
      off     = (ord_q == ORD_INTLV) ? ilv_off : seq_off;
      if (bl8_q) bst_col[i] = {base_q[COL_W-1:OFF_W], off};
      else       bst_col[i] = {base_q[COL_W-1:OFF_W-1], off[OFF_W-2:0]};
    end
  end

  // R9: a 4-beat burst never runs past its second pair
  p_pair_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !bl8_q |-> cnt_q < CNT_W'(PAIRS_BL4));

  // R8: the two beats of a pair always name different columns
  p_pair_distinct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> bst_col[0] != bst_col[1]);

endmodule

// File: rtl/ddr2cs_rdv.sv
module ddr2cs_rdv #(
  parameter int MAX_RL = 5,
  parameter int MIN_RL = 3,
  parameter int RL_W   = $clog2(MAX_RL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_beat,
  input  logic [RL_W-1:0] rd_lat,
  output logic            rd_valid
);
  logic [MAX_RL-1:0] sh_q, sh_d;

  for (genvar k = 0; k < MAX_RL; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign sh_d[k] = rd_beat;
    end else begin : g_tail
      assign sh_d[k] = sh_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  always_comb begin
    rd_valid = 1'b0;
    for (int k = 0; k < MAX_RL; k++) begin
      if (rd_lat == RL_W'(k + 1)) rd_valid = sh_q[k];
    end
  end

  // R10: programmed latency must stay inside the supported range
  p_lat_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lat >= RL_W'(MIN_RL)) && (rd_lat <= RL_W'(MAX_RL)));

endmodule

// File: rtl/ddr2_col_seq.sv
module ddr2_col_seq
  import ddr2cs_pkg::*;
#(
  parameter int COL_W      = 12,
  parameter int MAX_RL     = 5,
  parameter int MIN_RL     = 3,
  parameter int TCCD_SHORT = 2,
  parameter int TCCD_LONG  = 4,
  parameter int RL_W       = $clog2(MAX_RL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RL_W-1:0]  rd_lat,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_bl8,
  input  logic             req_intlv,
  input  logic             req_intr,
  input  logic [COL_W-1:0] req_col,
  output logic             cmd_cs_n,
  output logic             cmd_ras_n,
  output logic             cmd_cas_n,
  output logic             cmd_we_n,
  output logic [COL_W-1:0] cmd_col,
  output logic             bst_valid,
  output logic             bst_write,
  output logic [COL_W-1:0] bst_col_even,
  output logic [COL_W-1:0] bst_col_odd,
  output logic             rd_valid
);
  localparam int BPC = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             accept;
  pins_t            pins_q, pins_d;
  logic [COL_W-1:0] col_q;
  logic             bst_last, bst_bl8;
  logic [BPC-1:0][COL_W-1:0] cols;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign accept = req_valid & req_ready & rst_sync_n;

  ddr2cs_spacing #(
    .TCCD_SHORT(TCCD_SHORT),
    .TCCD_LONG (TCCD_LONG),
    .INTR_MIN  (TCCD_SHORT)
  ) u_spacing (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .accept   (accept),
    .req_bl8  (req_bl8),
    .req_write(req_write),
    .req_intr (req_intr),
    .ready    (req_ready)
  );

  ddr2cs_burst #(
    .COL_W (COL_W),
    .BPC   (BPC),
    .MAX_BL(2 * TCCD_LONG)
  ) u_burst (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (accept),
    .ld_col   (req_col),
    .ld_bl8   (req_bl8),
    .ld_intlv (req_intlv),
    .ld_write (req_write),
    .bst_valid(bst_valid),
    .bst_last (bst_last),
    .bst_bl8  (bst_bl8),
    .bst_write(bst_write),
    .bst_col  (cols)
  );

  assign bst_col_even = cols[0];
  assign bst_col_odd  = cols[1];

  ddr2cs_rdv #(
    .MAX_RL(MAX_RL),
    .MIN_RL(MIN_RL),
    .RL_W  (RL_W)
  ) u_rdv (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_beat (bst_valid & ~bst_write),
    .rd_lat  (rd_lat),
    .rd_valid(rd_valid)
  );

  always_comb begin
    pins_d = accept ? col_cmd(req_write) : PINS_NOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= PINS_NOP;
      col_q  <= '0;
    end else begin
      pins_q <= pins_d;
      if (accept) col_q <= req_col;
    end
  end

  assign cmd_cs_n  = pins_q.cs_n;
  assign cmd_ras_n = pins_q.ras_n;
  assign cmd_cas_n = pins_q.cas_n;
  assign cmd_we_n  = pins_q.we_n;
  assign cmd_col   = col_q;

  // R1: an accepted request shows up as a column command one clock later
  p_cmd_enc_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |=> (!cmd_cs_n && cmd_ras_n && !cmd_cas_n && (cmd_we_n == !$past(req_write))));

  // R2: no accepted request means NOP on the pins
  p_nop_idle_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !accept |=> (!cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n));

  // R4: a 4-beat burst is never cut in its first clock
  p_bl4_no_cut_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bst_valid && !bst_bl8 && !bst_last |-> !accept);

  // R6: every beat stays in the aligned block of the command's column
  p_block_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bst_valid |-> (bst_col_even[COL_W-1:3] == cmd_col[COL_W-1:3]) &&
                  (bst_col_odd[COL_W-1:3]  == cmd_col[COL_W-1:3]));

endmodule

// File: tb/ddr2_col_seq_tb_top.sv
`timescale 1ns/1ps
module ddr2_col_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rd_lat;
  logic        req_valid, req_ready, req_write, req_bl8, req_intlv, req_intr;
  logic [11:0] req_col;
  logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [11:0] cmd_col;
  logic        bst_valid, bst_write;
  logic [11:0] bst_col_even, bst_col_odd;
  logic        rd_valid;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  bit rvh [0:4095];

  always #5 clk = ~clk;

  ddr2_col_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rd_lat(rd_lat),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bl8(req_bl8), .req_intlv(req_intlv), .req_intr(req_intr), .req_col(req_col),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_col(cmd_col), .bst_valid(bst_valid), .bst_write(bst_write),
    .bst_col_even(bst_col_even), .bst_col_odd(bst_col_odd), .rd_valid(rd_valid)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) rvh[cyc % 4096] = rd_valid;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pins();
    return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
  endfunction

  // Called at a falling edge; returns at the falling edge of the command cycle.
  task automatic issue(input logic wr, input logic [11:0] col, input logic bl8,
                       input logic ilv, input logic intr, output int t0);
    req_valid = 1'b1; req_write = wr; req_col = col;
    req_bl8 = bl8; req_intlv = ilv; req_intr = intr;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    t0 = cyc;
    req_valid = 1'b0; req_intr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdv_window(input string req, input int t0, input int first, input int len);
    idle(12);
    for (int k = 0; k < 12; k++) begin
      logic e;
      e = (len > 0) && (k >= first) && (k < first + len);
      chk(req, {31'd0, rvh[(t0 + k) % 4096]}, {31'd0, e});
    end
  endtask

  task automatic t_reset();
    chk("R2 reset pins", {28'd0, pins()}, 32'h7);
    chk("R13 ready", {31'd0, req_ready}, 32'd1);
    chk("R13 bst_valid", {31'd0, bst_valid}, 32'd0);
    chk("R13 rd_valid", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_bl4_seq_read();
    int t0;
    rd_lat = 3'd3;
    issue(1'b0, 12'h005, 1'b0, 1'b0, 1'b0, t0);
    chk("R1 read pins", {28'd0, pins()}, 32'h5);
    chk("R1 cmd_col", {20'd0, cmd_col}, 32'h005);
    chk("R9 valid pair0", {31'd0, bst_valid}, 32'd1);
    chk("R9 bst_write read", {31'd0, bst_write}, 32'd0);
    chk("R6 even0", {20'd0, bst_col_even}, 32'h005);
    chk("R6 odd0", {20'd0, bst_col_odd}, 32'h006);
    @(negedge clk);
    chk("R2 nop after cmd", {28'd0, pins()}, 32'h7);
    chk("R6 even1", {20'd0, bst_col_even}, 32'h007);
    chk("R6 odd1", {20'd0, bst_col_odd}, 32'h004);
    @(negedge clk);
    chk("R9 valid ends", {31'd0, bst_valid}, 32'd0);
    rdv_window("R10 rl3 bl4", t0, 3, 2);
  endtask

  task automatic t_bl8_intlv_write();
    int t0;
    logic [11:0] ev [4] = '{12'h0A5, 12'h0A7, 12'h0A1, 12'h0A3};
    logic [11:0] od [4] = '{12'h0A4, 12'h0A6, 12'h0A0, 12'h0A2};
    issue(1'b1, 12'h0A5, 1'b1, 1'b1, 1'b0, t0);
    chk("R1 write pins", {28'd0, pins()}, 32'h4);
    chk("R9 bst_write", {31'd0, bst_write}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      chk("R8 bl8 even", {20'd0, bst_col_even}, {20'd0, ev[k]});
      chk("R8 bl8 odd", {20'd0, bst_col_odd}, {20'd0, od[k]});
      chk("R9 valid bl8", {31'd0, bst_valid}, 32'd1);
      @(negedge clk);
    end
    chk("R9 bl8 ends", {31'd0, bst_valid}, 32'd0);
    rdv_window("R10 write none", t0, 0, 0);
  endtask

  task automatic t_bl8_seq_read();
    int t0;
    logic [11:0] ev [4] = '{12'h3FE, 12'h3F8, 12'h3FA, 12'h3FC};
    logic [11:0] od [4] = '{12'h3FF, 12'h3F9, 12'h3FB, 12'h3FD};
    rd_lat = 3'd5;
    issue(1'b0, 12'h3FE, 1'b1, 1'b0, 1'b0, t0);
    for (int k = 0; k < 4; k++) begin
      chk("R7 seq8 even", {20'd0, bst_col_even}, {20'd0, ev[k]});
      chk("R7 seq8 odd", {20'd0, bst_col_odd}, {20'd0, od[k]});
      @(negedge clk);
    end
    rdv_window("R10 rl5 bl8", t0, 5, 4);
  endtask

  task automatic t_bl4_intlv();
    int t0;
    issue(1'b1, 12'h013, 1'b0, 1'b1, 1'b0, t0);
    chk("R8 ilv4 even0", {20'd0, bst_col_even}, 32'h013);
    chk("R8 ilv4 odd0", {20'd0, bst_col_odd}, 32'h012);
    @(negedge clk);
    chk("R8 ilv4 even1", {20'd0, bst_col_even}, 32'h011);
    chk("R8 ilv4 odd1", {20'd0, bst_col_odd}, 32'h010);
    idle(4);
  endtask

  task automatic t_spacing();
    int a, b;
    issue(1'b0, 12'h100, 1'b0, 1'b0, 1'b0, a);
    chk("R3 ready low while spacing", {31'd0, req_ready}, 32'd0);
    issue(1'b0, 12'h104, 1'b0, 1'b0, 1'b1, b);
    chk("R4 bl4 gap (R12 intr ignored)", b - a, 32'd2);
    chk("R3 held request issued", {20'd0, cmd_col}, 32'h104);
    idle(6);
    issue(1'b1, 12'h200, 1'b1, 1'b0, 1'b0, a);
    issue(1'b1, 12'h208, 1'b1, 1'b0, 1'b1, b);
    chk("R5 bl8 write gap, R12 write intr ignored", b - a, 32'd4);
    idle(6);
    issue(1'b0, 12'h300, 1'b1, 1'b0, 1'b0, a);
    issue(1'b0, 12'h304, 1'b0, 1'b0, 1'b1, b);
    chk("R5 bl8 gap, R12 bl4 intr ignored", b - a, 32'd4);
    idle(8);
  endtask

  task automatic t_gapless();
    int a, b;
    rd_lat = 3'd4;
    issue(1'b0, 12'h020, 1'b0, 1'b0, 1'b0, a);
    issue(1'b0, 12'h024, 1'b0, 1'b0, 1'b0, b);
    chk("R4 gap", b - a, 32'd2);
    rdv_window("R11 bl4 stream rl4", a, 4, 4);
    issue(1'b0, 12'h040, 1'b1, 1'b0, 1'b0, a);
    issue(1'b0, 12'h048, 1'b1, 1'b0, 1'b0, b);
    chk("R5 gap stream", b - a, 32'd4);
    idle(12);
    for (int k = 0; k < 14; k++) begin
      logic e;
      e = (k >= 4) && (k < 12);
      chk("R11 bl8 stream rl4", {31'd0, rvh[(a + k) % 4096]}, {31'd0, e});
    end
  endtask

  task automatic t_interrupt();
    int a, b;
    rd_lat = 3'd3;
    issue(1'b0, 12'h040, 1'b1, 1'b0, 1'b0, a);
    issue(1'b0, 12'h08A, 1'b1, 1'b0, 1'b1, b);
    chk("R12 interrupt gap", b - a, 32'd2);
    chk("R12 new burst even", {20'd0, bst_col_even}, 32'h08A);
    chk("R12 new burst odd", {20'd0, bst_col_odd}, 32'h08B);
    idle(3);
    chk("R12 new burst runs 4 pairs", {31'd0, bst_valid}, 32'd1);
    @(negedge clk);
    chk("R12 new burst ends", {31'd0, bst_valid}, 32'd0);
    rdv_window("R12 interrupted rd_valid", a, 3, 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_lat = 3'd3;
    req_valid = 1'b0; req_write = 1'b0; req_bl8 = 1'b0;
    req_intlv = 1'b0; req_intr = 1'b0; req_col = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_bl4_seq_read();
    t_bl8_intlv_write();
    t_bl8_seq_read();
    t_bl4_intlv();
    t_spacing();
    t_gapless();
    t_interrupt();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule